// File: doc/BRIEF.md
# Floating-Point Writeback Slot Scheduler

The block decides, for each instruction waiting in the decode stage of an in-order pipeline, whether it may issue. Its only concern is the floating-point register file, which has a single write port. Four instruction classes write that port: the add pipe (add, subtract and convert, latency 3), the multiplier (latency 7), the divider (latency 25, not pipelined), and moves from the integer side into the FP file (latency 1). An instruction issued in cycle t with latency L needs the write port in cycle t+L.

A one-bit-wide reservation register of 25 positions tracks future use of the port. It advances one position per clock, and position 0 means the port is written in the current cycle. At issue, the block tests the position that the candidate's result would occupy. If that position is already reserved, it holds the instruction in decode and sets nothing. On the next cycle it repeats the test against the advanced contents. The block also holds back a divide while the previous divide still occupies the divider. It does not track register dependencies and contains no arithmetic.

Top module: `fp_wb_slot_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, no write-port slot is reserved (`wb_busy` = 0) and the divider is idle (`div_busy` = 0).
- R2: The class code `id_op` is decoded as 2'b00 add pipe (latency 3), 2'b01 multiplier (latency 7), 2'b10 divider (latency 25) and 2'b11 integer-to-FP move (latency 1). An instruction issued in cycle t raises `wb_busy` in cycle t+L, where L is its latency.
- R3: If a valid instruction would need the write port in a cycle that is already reserved, `id_stall` is 1 and `id_issue` is 0 in that same cycle.
- R4: A stalled instruction reserves no slot. Its would-be cycle shows `wb_busy` only if another issued instruction owns that cycle.
- R5: A stalled instruction is tested again in every later cycle against the advanced reservations. It issues in the first cycle whose target slot is free.
- R6: After a divide issues in cycle t, `div_busy` is 1 in cycles t+1 to t+24. A divide presented in those cycles stalls, and a divide may issue again from cycle t+25.
- R7: A busy divider does not stall add, multiply or move instructions. Only a slot conflict can stall them.
- R8: With `id_valid` low, the block neither issues, stalls nor reserves anything.
- R9: The write port is never promised to two instructions in the same cycle. `id_issue` and `id_stall` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_valid | input | 1 | An FP-writing instruction is in decode |
| id_op | input | 2 | Class code of that instruction (see R2) |
| id_issue | output | 1 | Instruction leaves decode this cycle |
| id_stall | output | 1 | Instruction is held in decode this cycle |
| wb_busy | output | 1 | The write port is used in this cycle |
| div_busy | output | 1 | The divider holds an unfinished divide |

## Verification
`id_issue` and `id_stall` are combinational on the decode inputs, so they are due in the same cycle. `wb_busy` from an issue is due exactly L clock edges later, and `div_busy` follows a divide issue from the next edge for 24 cycles. The bench drives inputs on the falling edge and samples one time unit later. It compares each output against a model that keeps a calendar of absolute cycle numbers, so each result is checked in the exact cycle it is due and not in any neighbouring one. Directed sequences place a late instruction onto a slot already held by an earlier multiply, move or add. They also present divides throughout the repeat window and at its first free cycle.

// File: rtl/fp_wb_slot_sched.sv
module fp_wb_slot_sched #(
  parameter int DEPTH   = 25,
  parameter int ADD_LAT = 3,
  parameter int MUL_LAT = 7,
  parameter int DIV_LAT = 25,
  parameter int MOV_LAT = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       id_valid,
  input  logic [1:0] id_op,
  output logic       id_issue,
  output logic       id_stall,
  output logic       wb_busy,
  output logic       div_busy
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int CW = $clog2(DIV_LAT + 1);

  logic [DEPTH-1:0] slots;
  logic [DEPTH-1:0] ahead;
  logic [DEPTH-1:0] want;
  logic [LW-1:0]    lat;
  logic [CW-1:0]    div_left;
  logic             is_div, slot_hit, div_block;

  always_comb begin
    case (id_op)
      2'b00:   lat = LW'(ADD_LAT);
      2'b01:   lat = LW'(MUL_LAT);
      2'b10:   lat = LW'(DIV_LAT);
      default: lat = LW'(MOV_LAT);
    endcase
  end

  // next-cycle view: bit i is the port use i+1 cycles from now
  assign ahead     = slots >> 1;
  assign want      = DEPTH'(1) << (lat - LW'(1));
  assign slot_hit  = |(ahead & want);
  assign is_div    = (id_op == 2'b10);
  assign div_busy  = (div_left != '0);
  assign div_block = is_div && div_busy;
  assign id_stall  = id_valid && (slot_hit || div_block);
  assign id_issue  = id_valid && !id_stall;
  assign wb_busy   = slots[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots    <= '0;
      div_left <= '0;
    end else begin
      slots <= ahead | (id_issue ? want : '0);
      if (id_issue && is_div) div_left <= CW'(DIV_LAT - 1);
      else if (div_busy)      div_left <= div_left - CW'(1);
    end
  end
endmodule

module fp_wb_slot_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       id_valid,
  input logic [1:0] id_op,
  input logic       id_issue,
  input logic       id_stall,
  input logic       wb_busy,
  input logic       div_busy
);
  a_r9_issue_stall_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(id_issue && id_stall));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> (!id_issue && !id_stall));

  a_r6_div_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (id_issue && id_op == 2'b10) |=> div_busy);

  a_r6_div_held: assert property (@(posedge clk) disable iff (!rst_n)
    (div_busy && id_valid && id_op == 2'b10) |-> id_stall);

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!wb_busy && !div_busy));
endmodule

bind fp_wb_slot_sched fp_wb_slot_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_op(id_op),
  .id_issue(id_issue), .id_stall(id_stall), .wb_busy(wb_busy), .div_busy(div_busy)
);

// File: tb/sim_fp_wb_slot_sched.sv
module sim_fp_wb_slot_sched;
  localparam int PERIOD = 10;
  localparam int DIV_L  = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       id_valid = 1'b0;
  logic [1:0] id_op = 2'b00;
  logic       id_issue, id_stall, wb_busy, div_busy;

  int  n_run = 0, n_fail = 0;
  int  t = 0;
  int  last_div = -1000;
  bit  cal [0:255];
  bit  done = 0;

  always #(PERIOD/2) clk = ~clk;

  fp_wb_slot_sched u0 (.clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_op(id_op),
                       .id_issue(id_issue), .id_stall(id_stall),
                       .wb_busy(wb_busy), .div_busy(div_busy));

  function automatic int lat_of(input logic [1:0] op);
    case (op)
      2'b00: return 3;
      2'b01: return 7;
      2'b10: return DIV_L;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, what, t, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] op);
    int  l;
    bit  slot_c, div_c, exp_stall, exp_div;
    string tag;
    @(negedge clk);
    id_valid = v;
    id_op    = op;
    #1;
    l       = lat_of(op);
    exp_div = (t - last_div >= 1) && (t - last_div < DIV_L);
    slot_c  = cal[(t + l) % 256];
    div_c   = (op == 2'b10) && exp_div;
    exp_stall = v && (slot_c || div_c);
    if (!v)          tag = "R8";
    else if (div_c)  tag = "R6";
    else if (slot_c) tag = "R3";
    else if (exp_div) tag = "R7";   // non-divide issues while divider busy
    else             tag = "R5";
    chk(tag, "id_stall", id_stall, exp_stall);
    chk(tag, "id_issue", id_issue, v && !exp_stall);
    chk("R2 R4", "wb_busy", wb_busy, cal[t % 256]);
    chk("R6", "div_busy", div_busy, exp_div);
    cal[t % 256] = 0;
    if (v && !exp_stall) begin
      cal[(t + l) % 256] = 1;
      if (op == 2'b10) last_div = t;
    end
    t++;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) cal[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "wb_busy in reset", wb_busy, 1'b0);
    chk("R1", "div_busy in reset", div_busy, 1'b0);
    chk("R8", "id_issue in reset idle", id_issue, 1'b0);
    rst_n = 1'b1;
    // R1: quiet cycles right after reset
    repeat (3) step(1'b0, 2'b00);
    // R3 / R5: add lands on a multiply's slot, then slides by one
    step(1'b1, 2'b01);
    repeat (3) step(1'b0, 2'b00);
    step(1'b1, 2'b00);
    step(1'b1, 2'b00);
    repeat (10) step(1'b0, 2'b00);
    // R3: move collides with an add two cycles earlier
    step(1'b1, 2'b00);
    step(1'b0, 2'b00);
    step(1'b1, 2'b11);
    step(1'b1, 2'b11);
    repeat (5) step(1'b0, 2'b00);
    // back-to-back moves all issue
    repeat (6) step(1'b1, 2'b11);
    repeat (3) step(1'b0, 2'b00);
    // R6 / R7: divide window, other classes pass, divide again at t+25
    step(1'b1, 2'b10);
    repeat (4) step(1'b1, 2'b10);
    step(1'b1, 2'b00);
    step(1'b1, 2'b01);
    repeat (17) step(1'b1, 2'b10);
    step(1'b1, 2'b10);
    step(1'b1, 2'b10);
    repeat (30) step(1'b0, 2'b00);
    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic v;
      logic [1:0] op;
      v  = ($urandom % 10) < 7;
      op = 2'($urandom % 4);
      step(v, op);
    end
    repeat (30) step(1'b0, 2'b00);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule